// File: doc/BRIEF.md
# Stackable Bit-Addressed Parallel Printer Port

This block is one card of a PC-style parallel printer port that sits on a serial I/O bus where each access moves a single bit. Each status line and each control line has its own bit index, counted from the card's base address on that bus. The eight data lines are handled separately, through one byte location on the memory bus. Up to four cards can share the two buses. The parameter `CARD_SEL` (0 to 3) places each card at its own bit-bus base and its own data byte address.

Software drives the printer by writing control bits and reading status bits one at a time. The data byte goes through the memory location. A direction bit turns the data lines around: in output mode the card drives its latched byte onto the pins, and in input mode it releases the pins and reads their levels back. A card-enable bit gates the data path. An LED bit is kept for software to use. All external inputs are synchronized before anything reads them. The bit-bus and memory-bus read results are registered and appear one clock after the request.

Top module: `lpt_bitbus_card`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every control output, `led_o`, `pd_oe`, `pd_out`, `bb_rbit` and `mem_rdata` is 0. The card starts disabled, with the direction set to output.
- R2: The card responds on the bit bus only to addresses 0x1000 + 0x10*CARD_SEL through that value + 15. Bit index = address minus base. Accesses to any other address change no state, and a read of one returns `bb_rbit` = 0.
- R3: A bit-bus write sets each control output to `bb_wdata` at these indices: strobe at 2, initialise at 4, select-printer at 5, auto-linefeed at 6. The output changes in the cycle after the write and holds until the same index is written again.
- R4: A bit-bus read returns the synchronized input pins at these indices: busy at 2, error at 3, paper-out at 4, select at 5, acknowledge at 6. The result appears on `bb_rbit` one cycle after `bb_rd`.
- R5: The internal bits can be written and read back at the same index: card enable at 0, direction at 1 (1 = input), LED at 7. The LED bit also drives `led_o`.
- R6: Reads of indices 8 to 15 return 0. Writes to index 3 and to indices 8 to 15 are ignored.
- R7: A memory write to 0x5000 + 2*CARD_SEL on an enabled card latches `mem_wdata` onto `pd_out`. In output direction, a memory read there returns the latch one cycle later.
- R8: With direction set to input, `pd_oe` is 0 and a data read returns the synchronized `pd_in` levels. With the card enabled and direction set to output, `pd_oe` is 1.
- R9: On a disabled card, data writes are ignored, data reads return 0 and `pd_oe` is 0.
- R10: `mem_rdata` is 0 in any cycle not preceded by a data read of this card, and `bb_rbit` is 0 in any cycle not preceded by a bit-bus read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bb_addr | input | 16 | Bit-bus address |
| bb_wr | input | 1 | Bit-bus write strobe |
| bb_wdata | input | 1 | Bit value to write |
| bb_rd | input | 1 | Bit-bus read request |
| bb_rbit | output | 1 | Registered bit-read result |
| mem_addr | input | 16 | Memory-bus address |
| mem_wr | input | 1 | Memory write strobe |
| mem_rd | input | 1 | Memory read request |
| mem_wdata | input | 8 | Data byte to write |
| mem_rdata | output | 8 | Registered data-read result |
| pd_out | output | 8 | Data byte driven toward the pins |
| pd_oe | output | 1 | Data pin driver enable |
| pd_in | input | 8 | Data pin levels |
| busy_i | input | 1 | Printer busy |
| err_i | input | 1 | Printer error |
| pout_i | input | 1 | Paper out |
| sel_i | input | 1 | Printer selected |
| ack_i | input | 1 | Acknowledge |
| strobe_o | output | 1 | Strobe control |
| init_o | output | 1 | Initialise control |
| selprn_o | output | 1 | Select-printer control |
| autolf_o | output | 1 | Auto-linefeed control |
| led_o | output | 1 | LED state |

## Verification
The assertions check, on every cycle, the things that must not happen without a cause. Control and LED outputs may not change without a write to this card. The data latch may not change without a data write. Read results must be zero when no read was made, a bit read aimed at another card returns zero, and a written LED value must appear the next cycle. Only the bench's scenarios can show the full index map: which input pin each status index returns, how reads depend on the direction and enable bits, and that writes to unused indices leave every observable bit unchanged. The bench checks these against a model, under random pin levels and a random mix of accesses.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int IDX_W = 4;

  localparam int IX_EN     = 0;
  localparam int IX_DIR    = 1;
  localparam int IX_STROBE = 2;
  localparam int IX_BUSY   = 2;
  localparam int IX_ERR    = 3;
  localparam int IX_INIT   = 4;
  localparam int IX_POUT   = 4;
  localparam int IX_SELPRN = 5;
  localparam int IX_SEL    = 5;
  localparam int IX_AUTOLF = 6;
  localparam int IX_ACK    = 6;
  localparam int IX_LED    = 7;

  typedef struct packed {
    logic autolf;
    logic selprn;
    logic init;
    logic strobe;
  } lpt_ctrl_t;

  typedef struct packed {
    logic ack;
    logic sel;
    logic pout;
    logic err;
    logic busy;
  } lpt_stat_t;

  localparam int STAT_W = $bits(lpt_stat_t);
endpackage

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int BB_BASE = 'h1000,
  parameter int MEM_LOC = 'h5000
) (
  input  logic [ADDR_W-1:0] bb_addr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              bb_hit,
  output logic [IDX_W-1:0]  bb_idx,
  output logic              mem_hit
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BB_BASE);
  localparam logic [ADDR_W-1:0] LOC_V  = ADDR_W'(MEM_LOC);

  always_comb begin
    bb_hit  = (bb_addr[ADDR_W-1:IDX_W] == BASE_V[ADDR_W-1:IDX_W]);
    bb_idx  = bb_addr[IDX_W-1:0];
    mem_hit = (mem_addr == LOC_V);
  end
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/lpt_ctrl_regs.sv
module lpt_ctrl_regs
  import lpt_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic          wbit,
  output lpt_ctrl_t     ctrl,
  output logic          card_en,
  output logic          dir_in,
  output logic          led
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      card_en <= 1'b0;
      dir_in  <= 1'b0;
      led     <= 1'b0;
    end else if (wr_en) begin
      case (int'(idx))
        IX_EN:     card_en     <= wbit;
        IX_DIR:    dir_in      <= wbit;
        IX_STROBE: ctrl.strobe <= wbit;
        IX_INIT:   ctrl.init   <= wbit;
        IX_SELPRN: ctrl.selprn <= wbit;
        IX_AUTOLF: ctrl.autolf <= wbit;
        IX_LED:    led         <= wbit;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/lpt_data_port.sv
module lpt_data_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          card_en,
  input  logic          dir_in,
  input  logic [DW-1:0] pins_sync,
  output logic [DW-1:0] latch,
  output logic          oe,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      rdata <= '0;
    end else begin
      if (wr && card_en) latch <= wdata;
      if (rd && card_en) rdata <= dir_in ? pins_sync : latch;
      else               rdata <= '0;
    end
  end

  assign oe = card_en & ~dir_in;
endmodule

// File: rtl/lpt_bitbus_card.sv
module lpt_bitbus_card
  import lpt_pkg::*;
#(
  parameter int CARD_SEL    = 0,
  parameter int ADDR_W      = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BB_BASE0    = 'h1000,
  parameter int BB_STRIDE   = 'h10,
  parameter int MEM_BASE0   = 'h5000,
  parameter int MEM_STRIDE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bb_addr,
  input  logic              bb_wr,
  input  logic              bb_wdata,
  input  logic              bb_rd,
  output logic              bb_rbit,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wr,
  input  logic              mem_rd,
  input  logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  input  logic [DW-1:0]     pd_in,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic              pout_i,
  input  logic              sel_i,
  input  logic              ack_i,
  output logic              strobe_o,
  output logic              init_o,
  output logic              selprn_o,
  output logic              autolf_o,
  output logic              led_o
);
  localparam int BB_BASE = BB_BASE0 + CARD_SEL * BB_STRIDE;
  localparam int MEM_LOC = MEM_BASE0 + CARD_SEL * MEM_STRIDE;

  logic             bb_hit, mem_hit;
  logic [IDX_W-1:0] bb_idx;
  lpt_ctrl_t        ctrl;
  lpt_stat_t        stat_raw, stat_s;
  logic             card_en, dir_in, led;
  logic [DW-1:0]    pins_s;
  logic             rbit_nxt;

  lpt_addr_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BB_BASE(BB_BASE), .MEM_LOC(MEM_LOC)
  ) u_dec (
    .bb_addr(bb_addr), .mem_addr(mem_addr),
    .bb_hit(bb_hit), .bb_idx(bb_idx), .mem_hit(mem_hit)
  );

  lpt_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(bb_wr && bb_hit), .idx(bb_idx),
    .wbit(bb_wdata), .ctrl(ctrl), .card_en(card_en), .dir_in(dir_in), .led(led)
  );

  always_comb begin
    stat_raw.busy = busy_i;
    stat_raw.err  = err_i;
    stat_raw.pout = pout_i;
    stat_raw.sel  = sel_i;
    stat_raw.ack  = ack_i;
  end

  lpt_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(clk), .rst(rst), .d(stat_raw), .q(stat_s)
  );

  lpt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pd_in), .q(pins_s)
  );

  lpt_data_port #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .wr(mem_wr && mem_hit), .rd(mem_rd && mem_hit),
    .wdata(mem_wdata), .card_en(card_en), .dir_in(dir_in), .pins_sync(pins_s),
    .latch(pd_out), .oe(pd_oe), .rdata(mem_rdata)
  );

  always_comb begin
    case (int'(bb_idx))
      IX_EN:   rbit_nxt = card_en;
      IX_DIR:  rbit_nxt = dir_in;
      IX_BUSY: rbit_nxt = stat_s.busy;
      IX_ERR:  rbit_nxt = stat_s.err;
      IX_POUT: rbit_nxt = stat_s.pout;
      IX_SEL:  rbit_nxt = stat_s.sel;
      IX_ACK:  rbit_nxt = stat_s.ack;
      IX_LED:  rbit_nxt = led;
      default: rbit_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bb_rbit <= 1'b0;
    else     bb_rbit <= bb_rd && bb_hit && rbit_nxt;
  end

  assign strobe_o = ctrl.strobe;
  assign init_o   = ctrl.init;
  assign selprn_o = ctrl.selprn;
  assign autolf_o = ctrl.autolf;
  assign led_o    = led;
endmodule

// File: rtl/lpt_bitbus_card_chk.sv
module lpt_bitbus_card_chk #(
  parameter int CARD_SEL  = 0,
  parameter int ADDR_W    = 16,
  parameter int DW        = 8,
  parameter int BB_BASE0  = 'h1000,
  parameter int BB_STRIDE = 'h10,
  parameter int MEM_BASE0 = 'h5000,
  parameter int MEM_STRIDE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bb_addr,
  input logic              bb_wr,
  input logic              bb_wdata,
  input logic              bb_rd,
  input logic              bb_rbit,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic [DW-1:0]     mem_rdata,
  input logic [DW-1:0]     pd_out,
  input logic              strobe_o,
  input logic              init_o,
  input logic              selprn_o,
  input logic              autolf_o,
  input logic              led_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BB_BASE0 + CARD_SEL * BB_STRIDE);
  localparam logic [ADDR_W-1:0] LOC  = ADDR_W'(MEM_BASE0 + CARD_SEL * MEM_STRIDE);

  logic own_bb, own_mem, own_led;
  assign own_bb  = (bb_addr >= BASE) && (bb_addr <= BASE + ADDR_W'(15));
  assign own_mem = (mem_addr == LOC);
  assign own_led = own_bb && (bb_addr == BASE + ADDR_W'(7));

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bb_wr && own_bb) |-> $stable({strobe_o, init_o, selprn_o, autolf_o, led_o})); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_wr && own_mem) |-> $stable(pd_out)); // R7
  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bb_rd && !own_bb) |-> !bb_rbit); // R2
  AST_IDLE_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(bb_rd) |-> !bb_rbit); // R10
  AST_IDLE_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_rd && own_mem) |-> (mem_rdata == '0)); // R10
  AST_LED_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(bb_wr && own_led) |-> (led_o == $past(bb_wdata))); // R5
endmodule

bind lpt_bitbus_card lpt_bitbus_card_chk #(
  .CARD_SEL(CARD_SEL), .ADDR_W(ADDR_W), .DW(DW), .BB_BASE0(BB_BASE0),
  .BB_STRIDE(BB_STRIDE), .MEM_BASE0(MEM_BASE0), .MEM_STRIDE(MEM_STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .bb_addr(bb_addr), .bb_wr(bb_wr), .bb_wdata(bb_wdata),
  .bb_rd(bb_rd), .bb_rbit(bb_rbit), .mem_addr(mem_addr), .mem_wr(mem_wr),
  .mem_rd(mem_rd), .mem_rdata(mem_rdata), .pd_out(pd_out), .strobe_o(strobe_o),
  .init_o(init_o), .selprn_o(selprn_o), .autolf_o(autolf_o), .led_o(led_o)
);

// File: tb/lpt_bitbus_card_bench.sv
module lpt_bitbus_card_bench;
  localparam int CARD = 2;
  localparam logic [15:0] BASE = 16'h1020;
  localparam logic [15:0] LOC  = 16'h5004;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bb_addr = '0, mem_addr = '0;
  logic bb_wr = 0, bb_wdata = 0, bb_rd = 0, mem_wr = 0, mem_rd = 0;
  logic [7:0] mem_wdata = '0, pd_in = '0;
  logic busy_i = 0, err_i = 0, pout_i = 0, sel_i = 0, ack_i = 0;
  logic bb_rbit, pd_oe, strobe_o, init_o, selprn_o, autolf_o, led_o;
  logic [7:0] mem_rdata, pd_out;

  int checks = 0, failures = 0;
  logic m_en = 0, m_dir = 0, m_led = 0, m_stb = 0, m_ini = 0, m_sp = 0, m_alf = 0;
  logic [7:0] m_latch = '0;

  always #2 clk = ~clk;

  lpt_bitbus_card #(.CARD_SEL(CARD)) u_lpt_bitbus_card (
    .clk(clk), .rst(rst), .bb_addr(bb_addr), .bb_wr(bb_wr), .bb_wdata(bb_wdata),
    .bb_rd(bb_rd), .bb_rbit(bb_rbit), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pd_out(pd_out),
    .pd_oe(pd_oe), .pd_in(pd_in), .busy_i(busy_i), .err_i(err_i), .pout_i(pout_i),
    .sel_i(sel_i), .ack_i(ack_i), .strobe_o(strobe_o), .init_o(init_o),
    .selprn_o(selprn_o), .autolf_o(autolf_o), .led_o(led_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bb_write(logic [15:0] a, logic v);
    @(negedge clk); bb_addr = a; bb_wdata = v; bb_wr = 1;
    @(negedge clk); bb_wr = 0;
    if (a >= BASE && a <= BASE + 15) begin
      case (int'(a - BASE))
        0: m_en = v;  1: m_dir = v; 2: m_stb = v; 4: m_ini = v;
        5: m_sp = v;  6: m_alf = v; 7: m_led = v; default: ;
      endcase
    end
  endtask

  task automatic bb_read(logic [15:0] a, output logic v);
    @(negedge clk); bb_addr = a; bb_rd = 1;
    @(negedge clk); bb_rd = 0; v = bb_rbit;
  endtask

  task automatic mem_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); mem_addr = a; mem_wdata = d; mem_wr = 1;
    @(negedge clk); mem_wr = 0;
    if (a == LOC && m_en) m_latch = d;
  endtask

  task automatic mem_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); mem_addr = a; mem_rd = 1;
    @(negedge clk); mem_rd = 0; d = mem_rdata;
  endtask

  task automatic set_pins(logic [4:0] s, logic [7:0] p);
    @(negedge clk);
    {ack_i, sel_i, pout_i, err_i, busy_i} = s; pd_in = p;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic exp_bit(int i);
    case (i)
      0: return m_en;   1: return m_dir;  2: return busy_i; 3: return err_i;
      4: return pout_i; 5: return sel_i;  6: return ack_i;  7: return m_led;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte();
    if (!m_en) return 8'h00;
    return m_dir ? pd_in : m_latch;
  endfunction

  task automatic check_outs(string req);
    check(req, {11'd0, strobe_o, init_o, selprn_o, autolf_o, led_o},
               {11'd0, m_stb, m_ini, m_sp, m_alf, m_led});
    check(req, {7'd0, pd_oe, pd_out}, {7'd0, m_en & ~m_dir, m_latch});
  endtask

  initial begin
    logic b;
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {bb_rbit, pd_oe, strobe_o, init_o, selprn_o, autolf_o, led_o, pd_out},
          16'h0000);
    check("R1 reset rdata", {8'd0, mem_rdata}, 16'h0000);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check_outs("R1 after reset");
    bb_read(BASE + 0, b); check("R1 card starts disabled", {15'd0, b}, 16'd0);

    // R3 control outputs, each index
    bb_write(BASE + 2, 1); check("R3 strobe", {15'd0, strobe_o}, 16'd1);
    bb_write(BASE + 4, 1); check("R3 init", {15'd0, init_o}, 16'd1);
    bb_write(BASE + 5, 1); bb_write(BASE + 6, 1);
    check_outs("R3 all set");
    bb_write(BASE + 2, 0); check_outs("R3 strobe clear, others hold");

    // R2 other cards and out-of-range addresses
    bb_write(16'h1000 + 5, 0); bb_write(16'h1030 + 6, 0); bb_write(16'h1010 + 7, 1);
    check_outs("R2 foreign writes ignored");
    set_pins(5'b11111, 8'hA5);
    bb_read(16'h1010 + 2, b); check("R2 foreign read zero", {15'd0, b}, 16'd0);
    bb_read(BASE + 16, b);    check("R2 next card read zero", {15'd0, b}, 16'd0);

    // R4 status map, one pin at a time
    for (int k = 0; k < 5; k++) begin
      set_pins(5'(1 << k), 8'h00);
      for (int i = 2; i <= 6; i++) begin
        bb_read(BASE + 16'(i), b);
        check("R4 status index", {15'd0, b}, {15'd0, exp_bit(i)});
      end
    end

    // R5 internal bits
    bb_write(BASE + 7, 1); check("R5 led out", {15'd0, led_o}, 16'd1);
    bb_read(BASE + 7, b);  check("R5 led readback", {15'd0, b}, 16'd1);
    bb_write(BASE + 0, 1); bb_read(BASE + 0, b); check("R5 enable readback", {15'd0, b}, 16'd1);

    // R6 unused indices
    set_pins(5'b00000, 8'h00);
    bb_write(BASE + 3, 1);
    for (int i = 8; i < 16; i++) bb_write(BASE + 16'(i), 1);
    check_outs("R6 ignored writes");
    for (int i = 8; i < 16; i++) begin
      bb_read(BASE + 16'(i), b); check("R6 unused reads zero", {15'd0, b}, 16'd0);
    end
    bb_read(BASE + 3, b); check("R6 index 3 still status", {15'd0, b}, 16'd0);

    // R7 data output path
    mem_write(LOC, 8'h3C); check_outs("R7 latch drive");
    mem_read(LOC, d); check("R7 readback", {8'd0, d}, 16'h003C);
    mem_write(LOC + 2, 8'hFF); check_outs("R7 other card address ignored");
    mem_read(LOC - 2, d); check("R10 other address read zero", {8'd0, d}, 16'd0);

    // R8 input direction
    bb_write(BASE + 1, 1); set_pins(5'b0, 8'hC3);
    check("R8 oe off", {15'd0, pd_oe}, 16'd0);
    mem_read(LOC, d); check("R8 pin read", {8'd0, d}, 16'h00C3);
    bb_write(BASE + 1, 0); check("R8 oe on", {15'd0, pd_oe}, 16'd1);

    // R9 disabled card
    bb_write(BASE + 0, 0);
    mem_write(LOC, 8'h99); check_outs("R9 disabled write ignored");
    mem_read(LOC, d); check("R9 disabled read zero", {8'd0, d}, 16'd0);
    @(negedge clk); check("R10 idle byte", {8'd0, mem_rdata}, 16'd0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op, idx;
      op = $urandom % 5; idx = $urandom % 16;
      case (op)
        0: begin bb_write(BASE + 16'(idx), 1'($urandom)); check_outs("R3 R5 random write"); end
        1: begin bb_read(BASE + 16'(idx), b);
             check("R4 R5 R6 random read", {15'd0, b}, {15'd0, exp_bit(idx)}); end
        2: begin mem_write(LOC, 8'($urandom)); check_outs("R7 R9 random data write"); end
        3: begin mem_read(LOC, d); check("R7 R8 R9 random data read", {8'd0, d}, {8'd0, exp_byte()}); end
        default: set_pins(5'($urandom), 8'($urandom));
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule